// File: doc/BRIEF.md
# Processor Bus Region Decoder

This block sits between a 32-bit processor bus and the memories and peripheral registers behind it. For each access it aligns the address to the access size, works out the byte lanes, and picks exactly one region: main RAM, work RAM, an I/O register window, palette RAM, video RAM or a boot ROM window. It raises that region's select, masks the address down to the region's local size so that a small array mirrors across its whole window, and returns read data from the selected memory. Accesses that hit no region raise a decode-error strobe and read as zero.

A handful of control registers live inside the I/O window. There is a sticky interrupt flag register that hardware sources set and software clears by writing ones, a one-bit interrupt master enable, and a halt-control byte whose top two bits request run or halt. Every other I/O offset reads as zero and ignores writes. The memories are outside the block: they see the select, the local address and the byte enables, and they return data on a shared read port.

Top module: `bus_region_dec`

## Requirements
- R1: With rd_i or wr_i high, an address whose top byte is 0x02 raises sel_o[0] (main RAM), and local_addr_o is the aligned address masked to MAIN_AW bits (0x003F_FFFF by default).
- R2: Top byte 0x03 raises sel_o[1] (work RAM, local mask 2^WRAM_AW-1, 0x7FFF by default), and top byte 0x06 raises sel_o[4] (video RAM, local mask 2^VRAM_AW-1, 0xF_FFFF by default).
- R3: Top byte 0x05 raises sel_o[3] (palette RAM), and local_addr_o is the aligned address masked with 0x7FF (PAL_AW = 11).
- R4: Top byte 0x04 raises sel_o[2] (I/O window, local mask 0xFF_FFFF). Upper halfword 0xFFFF raises sel_o[5] (boot ROM, local mask 2^ROM_AW-1, 0xFFFF by default).
- R5: An access with rd_i or wr_i high to any other address drives dec_err_o high in that cycle, with sel_o and local_addr_o all zero and rdata_o zero. At most one sel_o bit is ever high, and with both strobes low no select and no error is raised.
- R6: size_i encodes 00 byte, 01 halfword, 10 word and 11 word. A byte access keeps the address and sets be_o = 1 << addr[1:0]. A halfword access clears addr bit 0 and sets be_o to 0011 or 1100 by addr bit 1. A word access clears addr[1:0] and sets be_o to 1111.
- R7: A read that selects a memory region (any select except the I/O window) returns mem_rdata_i on rdata_o in the same cycle.
- R8: An I/O offset that is not one of the three control registers reads as zero, and a write to it changes no register. The I/O window does not mirror: the offsets are decoded on all 24 local bits.
- R9: The interrupt flag register sits at I/O offset 0x10. On each clock edge, every bit high on irq_src_i is set. A word-sized write (size 10 or 11) clears each flag whose wdata_i bit is one. A source bit wins over a clear of the same bit in the same cycle, and non-word writes are ignored. A read returns the flags zero-extended, bit i being flag i, and irq_flags_o shows them.
- R10: The interrupt master enable sits at I/O offset 0x08. A write that enables byte lane 0 stores wdata_i[0] into ime_o. A write that leaves lane 0 disabled has no effect. A read returns ime in bit 0, and all other bits are zero.
- R11: The halt-control byte sits at I/O offset 0x0D, which is lane 1, so its field is wdata_i[15:14]. A byte write with field 00 clears halt_o and field 10 sets it. Fields 01 and 11 leave halt_o unchanged and pulse unimpl_o for one cycle after the write. Writes of any other size to this byte are ignored.
- R12: After reset, irq_flags_o, ime_o, halt_o and unimpl_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Bus byte address |
| size_i | input | 2 | Access size: 00 byte, 01 half, 10/11 word |
| wdata_i | input | 32 | Write data, already placed on its byte lanes |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| mem_rdata_i | input | 32 | Read data from the selected memory |
| irq_src_i | input | IRQ_W | Interrupt sources, one per flag |
| sel_o | output | 6 | One-hot region select: main, work, I/O, palette, video, ROM |
| local_addr_o | output | 32 | Aligned address masked to the selected region |
| be_o | output | 4 | Byte-lane enables |
| rdata_o | output | 32 | Read data returned to the processor |
| dec_err_o | output | 1 | Access hit no region |
| irq_flags_o | output | IRQ_W | Interrupt flag register |
| ime_o | output | 1 | Interrupt master enable |
| halt_o | output | 1 | Halt request |
| unimpl_o | output | 1 | One-cycle pulse for an unsupported halt-control code |

## Verification
The bench keeps the default region widths, so a 4 MiB main array, a 32 KiB work RAM and a 2 KiB palette show their mirroring with addresses high inside each 16 MiB window. It narrows IRQ_W to 16, which brings the zero-extension of the flag read and the truncation of irq_src_i into reach. The rest of the register map is left at its defaults, so the halt field lands on lane 1 and a halfword or lane-1 write to the enable word can show that it is ignored.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  localparam int unsigned NREG    = 6;
  localparam int unsigned RG_MAIN = 0;
  localparam int unsigned RG_WRAM = 1;
  localparam int unsigned RG_IO   = 2;
  localparam int unsigned RG_PAL  = 3;
  localparam int unsigned RG_VRAM = 4;
  localparam int unsigned RG_ROM  = 5;

  function automatic logic [31:0] low_mask(int unsigned w);
    if (w >= 32) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/bus_addr_align.sv
module bus_addr_align
  import bus_dec_pkg::*;
(
  input  logic [31:0] addr_i,
  input  logic [1:0]  size_i,
  output logic [31:0] addr_o,
  output logic [3:0]  be_o
);

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        addr_o = addr_i;
        be_o   = 4'b0001 << addr_i[1:0];
      end
      SZ_HALF: begin
        addr_o = {addr_i[31:1], 1'b0};
        be_o   = addr_i[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        addr_o = {addr_i[31:2], 2'b00};
        be_o   = 4'b1111;
      end
    endcase
  end

endmodule

// File: rtl/bus_region_match.sv
module bus_region_match #(
  parameter int unsigned                 NREG       = 6,
  parameter logic [NREG-1:0][31:0]       MATCH_MASK = '0,
  parameter logic [NREG-1:0][31:0]       MATCH_BASE = '0,
  parameter logic [NREG-1:0][31:0]       LOCAL_MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     addr_i,
  input  logic            req_i,
  output logic [NREG-1:0] sel_o,
  output logic [31:0]     local_o,
  output logic            err_o
);

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_rg
    assign hit[g] = req_i && ((addr_i & MATCH_MASK[g]) == MATCH_BASE[g]);
  end

  assign sel_o = hit;
  assign err_o = req_i && (hit == '0);

  always_comb begin
    local_o = '0;
    for (int g = 0; g < NREG; g++) begin
      if (hit[g]) local_o = local_o | (addr_i & LOCAL_MASK[g]);
    end
  end

  p_sel_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_err_nosel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sel_o == '0 && local_o == '0));
  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (sel_o == '0 && !err_o));

endmodule

// File: rtl/bus_io_regs.sv
module bus_io_regs
  import bus_dec_pkg::*;
#(
  parameter int unsigned IRQ_W    = 32,
  parameter logic [31:0] IRQ_OFF  = 32'h0000_0010,
  parameter logic [31:0] IME_OFF  = 32'h0000_0008,
  parameter logic [31:0] HALT_OFF = 32'h0000_000D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [31:0]      addr_i,
  input  logic [1:0]       size_i,
  input  logic             lane0_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic [IRQ_W-1:0] irq_src_i,
  output logic [31:0]      rdata_o,
  output logic [IRQ_W-1:0] irq_flags_o,
  output logic             ime_o,
  output logic             halt_o,
  output logic             unimpl_o
);

  localparam int unsigned HLANE = int'(HALT_OFF[1:0]);
  localparam int unsigned HBIT  = 8 * HLANE + 6;

  logic             irq_hit, ime_hit;
  logic             irq_clr, ime_wr, halt_wr;
  logic [1:0]       halt_code;
  logic [IRQ_W-1:0] flags_q, flags_d, clr_mask;
  logic             ime_q, halt_q, halt_d, unimpl_q, unimpl_d;

  assign irq_hit = sel_i && (addr_i[31:2] == IRQ_OFF[31:2]);
  assign ime_hit = sel_i && (addr_i[31:2] == IME_OFF[31:2]);

  assign irq_clr = irq_hit && wr_i && size_i[1];
  assign ime_wr  = ime_hit && wr_i && lane0_i;
  assign halt_wr = sel_i && wr_i && (size_i == SZ_BYTE) && (addr_i == HALT_OFF);

  assign halt_code = wdata_i[HBIT +: 2];
  assign clr_mask  = irq_clr ? wdata_i[IRQ_W-1:0] : '0;
  // sources take priority over a clear of the same bit
  assign flags_d   = (flags_q & ~clr_mask) | irq_src_i;

  always_comb begin
    halt_d   = halt_q;
    unimpl_d = 1'b0;
    if (halt_wr) begin
      unique case (halt_code)
        2'b00:   halt_d = 1'b0;
        2'b10:   halt_d = 1'b1;
        default: unimpl_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      ime_q    <= 1'b0;
      halt_q   <= 1'b0;
      unimpl_q <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      if (ime_wr) ime_q <= wdata_i[0];
      halt_q   <= halt_d;
      unimpl_q <= unimpl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (irq_hit)      rdata_o[IRQ_W-1:0] = flags_q;
    else if (ime_hit) rdata_o[0] = ime_q;
  end

  assign irq_flags_o = flags_q;
  assign ime_o       = ime_q;
  assign halt_o      = halt_q;
  assign unimpl_o    = unimpl_q;

  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr && irq_src_i == '0) |=>
      (irq_flags_o == ($past(irq_flags_o) & ~$past(wdata_i[IRQ_W-1:0]))));
  p_src_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_src_i != '0) |=> ((irq_flags_o & $past(irq_src_i)) == $past(irq_src_i)));
  p_ime_store_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ime_wr |=> (ime_o == $past(wdata_i[0])));
  p_halt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_o |-> $stable(halt_o));

endmodule

// File: rtl/bus_region_dec.sv
module bus_region_dec
  import bus_dec_pkg::*;
#(
  parameter int unsigned MAIN_AW  = 22,
  parameter int unsigned WRAM_AW  = 15,
  parameter int unsigned IO_AW    = 24,
  parameter int unsigned PAL_AW   = 11,
  parameter int unsigned VRAM_AW  = 20,
  parameter int unsigned ROM_AW   = 16,
  parameter int unsigned IRQ_W    = 32,
  parameter logic [31:0] IRQ_OFF  = 32'h0000_0010,
  parameter logic [31:0] IME_OFF  = 32'h0000_0008,
  parameter logic [31:0] HALT_OFF = 32'h0000_000D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      addr_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      wdata_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic [IRQ_W-1:0] irq_src_i,
  output logic [5:0]       sel_o,
  output logic [31:0]      local_addr_o,
  output logic [3:0]       be_o,
  output logic [31:0]      rdata_o,
  output logic             dec_err_o,
  output logic [IRQ_W-1:0] irq_flags_o,
  output logic             ime_o,
  output logic             halt_o,
  output logic             unimpl_o
);

  localparam logic [31:0] TOP8  = 32'hFF00_0000;
  localparam logic [31:0] TOP16 = 32'hFFFF_0000;

  // index order: rom, vram, pal, io, wram, main
  localparam logic [NREG-1:0][31:0] M_MASK = {TOP16, TOP8, TOP8, TOP8, TOP8, TOP8};
  localparam logic [NREG-1:0][31:0] M_BASE = {
    32'hFFFF_0000, 32'h0600_0000, 32'h0500_0000,
    32'h0400_0000, 32'h0300_0000, 32'h0200_0000};
  localparam logic [NREG-1:0][31:0] L_MASK = {
    low_mask(ROM_AW), low_mask(VRAM_AW), low_mask(PAL_AW),
    low_mask(IO_AW),  low_mask(WRAM_AW), low_mask(MAIN_AW)};

  logic [31:0]     addr_al;
  logic [NREG-1:0] sel;
  logic [31:0]     io_rdata;
  logic            mem_sel;

  bus_addr_align u_align (
    .addr_i (addr_i),
    .size_i (size_i),
    .addr_o (addr_al),
    .be_o   (be_o)
  );

  bus_region_match #(
    .NREG       (NREG),
    .MATCH_MASK (M_MASK),
    .MATCH_BASE (M_BASE),
    .LOCAL_MASK (L_MASK)
  ) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_al),
    .req_i   (rd_i || wr_i),
    .sel_o   (sel),
    .local_o (local_addr_o),
    .err_o   (dec_err_o)
  );

  bus_io_regs #(
    .IRQ_W    (IRQ_W),
    .IRQ_OFF  (IRQ_OFF),
    .IME_OFF  (IME_OFF),
    .HALT_OFF (HALT_OFF)
  ) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel[RG_IO]),
    .addr_i      (local_addr_o),
    .size_i      (size_i),
    .lane0_i     (be_o[0]),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .irq_src_i   (irq_src_i),
    .rdata_o     (io_rdata),
    .irq_flags_o (irq_flags_o),
    .ime_o       (ime_o),
    .halt_o      (halt_o),
    .unimpl_o    (unimpl_o)
  );

  assign mem_sel = |(sel & ~(NREG'(1) << RG_IO));
  assign sel_o   = sel;

  always_comb begin
    if (mem_sel)        rdata_o = mem_rdata_i;
    else if (sel[RG_IO]) rdata_o = io_rdata;
    else                rdata_o = '0;
  end

  p_pal_local_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[RG_PAL] |-> ((local_addr_o & ~low_mask(PAL_AW)) == '0));
  p_err_rdata_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_o |-> (rdata_o == '0));

endmodule

// File: tb/tb_bus_region_dec.sv
module tb_bus_region_dec;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned IRQ_W      = 16;
  localparam logic [31:0] MEMD       = 32'hA5A5_5A5A;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [5:0]  sel;
    logic [31:0] loc;
    logic [3:0]  be;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  localparam int unsigned NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0212_3456, 2'b10, 6'b000001, 32'h0012_3454, 4'b1111, 1'b0, MEMD},
    '{32'h02C0_0001, 2'b00, 6'b000001, 32'h0000_0001, 4'b0010, 1'b0, MEMD},
    '{32'h0301_8003, 2'b01, 6'b000010, 32'h0000_0002, 4'b1100, 1'b0, MEMD},
    '{32'h0400_0106, 2'b01, 6'b000100, 32'h0000_0106, 4'b1100, 1'b0, 32'h0},
    '{32'h0500_0FFE, 2'b01, 6'b001000, 32'h0000_07FE, 4'b1100, 1'b0, MEMD},
    '{32'h0512_3801, 2'b00, 6'b001000, 32'h0000_0001, 4'b0010, 1'b0, MEMD},
    '{32'h06AB_CDEF, 2'b00, 6'b010000, 32'h000B_CDEF, 4'b1000, 1'b0, MEMD},
    '{32'hFFFF_1237, 2'b11, 6'b100000, 32'h0000_1234, 4'b1111, 1'b0, MEMD},
    '{32'hFFFE_FFFF, 2'b10, 6'b000000, 32'h0000_0000, 4'b1111, 1'b1, 32'h0},
    '{32'h0100_0000, 2'b10, 6'b000000, 32'h0000_0000, 4'b1111, 1'b1, 32'h0},
    '{32'h0700_0000, 2'b01, 6'b000000, 32'h0000_0000, 4'b0011, 1'b1, 32'h0},
    '{32'h0000_0010, 2'b00, 6'b000000, 32'h0000_0000, 4'b0001, 1'b1, 32'h0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      addr = '0;
  logic [1:0]       size = '0;
  logic [31:0]      wdata = '0;
  logic             rd = 1'b0;
  logic             wr = 1'b0;
  logic [31:0]      mem_rdata = MEMD;
  logic [IRQ_W-1:0] irq_src = '0;
  logic [5:0]       sel;
  logic [31:0]      local_addr;
  logic [3:0]       be;
  logic [31:0]      rdata;
  logic             dec_err;
  logic [IRQ_W-1:0] irq_flags;
  logic             ime;
  logic             halt;
  logic             unimpl;

  int n_total = 0;
  int n_pass  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_region_dec #(.IRQ_W(IRQ_W)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .size_i       (size),
    .wdata_i      (wdata),
    .rd_i         (rd),
    .wr_i         (wr),
    .mem_rdata_i  (mem_rdata),
    .irq_src_i    (irq_src),
    .sel_o        (sel),
    .local_addr_o (local_addr),
    .be_o         (be),
    .rdata_o      (rdata),
    .dec_err_o    (dec_err),
    .irq_flags_o  (irq_flags),
    .ime_o        (ime),
    .halt_o       (halt),
    .unimpl_o     (unimpl)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
  endtask

  function automatic string region_tag(input logic [5:0] s);
    case (s)
      6'b000001:           return "R1";
      6'b000010, 6'b010000: return "R2";
      6'b001000:           return "R3";
      6'b000100, 6'b100000: return "R4";
      default:             return "R5";
    endcase
  endfunction

  task automatic bus_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d,
                           input logic [IRQ_W-1:0] src);
    @(negedge clk);
    addr = a; size = s; wdata = d; wr = 1'b1; irq_src = src;
    @(negedge clk);
    wr = 1'b0; irq_src = '0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    addr = a; size = s; rd = 1'b1;
    #1;
  endtask

  task automatic irq_pulse(input logic [IRQ_W-1:0] v);
    @(negedge clk);
    irq_src = v;
    @(negedge clk);
    irq_src = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 flags", 32'(irq_flags), 32'h0);
    check("R12 ime", 32'(ime), 32'h0);
    check("R12 halt", 32'(halt), 32'h0);
    check("R12 unimpl", 32'(unimpl), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // idle: no strobe, no select or error
    addr = 32'h0100_0000; size = 2'b10; #1;
    check("R5 idle err", 32'(dec_err), 32'h0);
    addr = 32'h0200_0000; #1;
    check("R5 idle sel", 32'(sel), 32'h0);

    // region table walk
    for (int i = 0; i < NVEC; i++) begin
      bus_read(VECS[i].addr, VECS[i].size);
      check(region_tag(VECS[i].sel), 32'(sel), 32'(VECS[i].sel));
      check(region_tag(VECS[i].sel), local_addr, VECS[i].loc);
      check("R6 lanes", 32'(be), 32'(VECS[i].be));
      check("R5 err", 32'(dec_err), 32'(VECS[i].err));
      check(VECS[i].sel == 6'b000100 ? "R8 io rdata" : "R7 rdata", rdata, VECS[i].rdata);
    end
    @(negedge clk); rd = 1'b0;

    // R9 interrupt flags
    irq_pulse(16'h00F3);
    check("R9 set", 32'(irq_flags), 32'h00F3);
    bus_read(32'h0400_0010, 2'b10);
    check("R9 read", rdata, 32'h0000_00F3);
    @(negedge clk); rd = 1'b0;
    bus_write(32'h0400_0010, 2'b10, 32'h0000_0011, '0);
    check("R9 w1c", 32'(irq_flags), 32'h00E2);
    bus_write(32'h0400_0010, 2'b01, 32'h0000_FFFF, '0);
    check("R9 half ignored", 32'(irq_flags), 32'h00E2);
    bus_write(32'h0400_0010, 2'b10, 32'h0000_0002, 16'h0002);
    check("R9 set wins", 32'(irq_flags), 32'h00E2);
    bus_write(32'h0400_0010, 2'b11, 32'h0000_0022, '0);
    check("R9 w1c wide", 32'(irq_flags), 32'h00C0);

    // R10 master enable
    bus_write(32'h0400_0008, 2'b10, 32'h0000_0001, '0);
    check("R10 set", 32'(ime), 32'h1);
    bus_read(32'h0400_0008, 2'b10);
    check("R10 read", rdata, 32'h0000_0001);
    @(negedge clk); rd = 1'b0;
    bus_write(32'h0400_0009, 2'b00, 32'h0000_0000, '0);
    check("R10 lane1 ignored", 32'(ime), 32'h1);
    bus_write(32'h0400_000A, 2'b01, 32'h0000_0000, '0);
    check("R10 upper half ignored", 32'(ime), 32'h1);
    bus_write(32'h0400_0008, 2'b00, 32'h0000_00FE, '0);
    check("R10 clear", 32'(ime), 32'h0);
    bus_write(32'h0400_0008, 2'b10, 32'h0000_0001, '0);

    // R8 unmapped and mirrored I/O writes
    bus_write(32'h0400_0014, 2'b10, 32'hFFFF_FFFF, '0);
    check("R8 flags", 32'(irq_flags), 32'h00C0);
    check("R8 ime", 32'(ime), 32'h1);
    bus_write(32'h0410_0010, 2'b10, 32'hFFFF_FFFF, '0);
    check("R8 no mirror", 32'(irq_flags), 32'h00C0);
    bus_write(32'h0410_0008, 2'b10, 32'h0000_0000, '0);
    check("R8 no mirror ime", 32'(ime), 32'h1);

    // R11 halt control
    bus_write(32'h0400_000D, 2'b00, 32'h0000_8000, '0);
    check("R11 halt", 32'(halt), 32'h1);
    check("R11 no unimpl", 32'(unimpl), 32'h0);
    bus_write(32'h0400_000D, 2'b00, 32'h0000_4000, '0);
    check("R11 code01 hold", 32'(halt), 32'h1);
    check("R11 code01 unimpl", 32'(unimpl), 32'h1);
    @(negedge clk);
    check("R11 unimpl pulse", 32'(unimpl), 32'h0);
    bus_write(32'h0400_000D, 2'b00, 32'h0000_C000, '0);
    check("R11 code11 hold", 32'(halt), 32'h1);
    check("R11 code11 unimpl", 32'(unimpl), 32'h1);
    bus_write(32'h0400_000D, 2'b00, 32'h0000_0000, '0);
    check("R11 run", 32'(halt), 32'h0);
    bus_write(32'h0400_000C, 2'b10, 32'h0000_8000, '0);
    check("R11 word ignored", 32'(halt), 32'h0);
    bus_read(32'h0400_000C, 2'b10);
    check("R8 halt reads zero", rdata, 32'h0);
    @(negedge clk); rd = 1'b0;

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule